// File: doc/BRIEF.md
# Sector-Mapped Buffer Directory

This block is the lookup directory for a small buffer that sits in front of a large backing store. The buffer is split into a few sectors. Any sector can hold any region of the backing store, and a stored sector tag names the region it holds. Inside a sector, a block always sits at the slot given by its address bits. One tag therefore covers sixteen blocks, and each block has its own valid bit.

Every request is compared against all sector tags in the same cycle. One cycle later the directory returns one of three results:

- **Hit:** the tag matches and the block is present.
- **Block miss:** the tag matches, but the block has not been filled yet.
- **Sector miss:** no tag matches.

On a read that misses its sector, the directory installs the new tag into the sector chosen by an external replacement unit. It then empties that sector of blocks. Fills arrive on a separate port, one block at a time. Writes use store-through: every write is passed on to the backing store. A write that misses allocates nothing.

The default build has 4 sectors, 16-bit word addresses, 4-word blocks and 16 blocks per sector. This gives a 10-bit sector tag.

Top module: `sector_dir`

## Requirements
- R1: Synchronous reset clears every sector-valid and block-valid bit and drives all response outputs low. The first read after reset is a sector miss.
- R2: The address splits into three fields. Bits 15:6 are the sector tag. Bits 5:2 pick the block slot within the sector. Bits 1:0 (word in block) have no effect on the lookup.
- R3: The response to a request accepted at a clock edge appears at the next edge, with `rsp_valid` high. Exactly one of `rsp_hit`, `rsp_blk_miss` and `rsp_sec_miss` is then high. All three are low whenever `rsp_valid` is low.
- R4: A read sector miss does four things:
  - it writes the request's tag into the sector named by `victim_sector`;
  - it marks that sector valid;
  - it clears all 16 of its block-valid bits;
  - it reports that sector index on `rsp_sector`.
- R5: A fill marks block `fill_block` of sector `fill_sector` valid. A later read of that block returns a hit with that sector index.
- R6: A tag match on a block whose valid bit is clear is a block miss. The response reports the matching sector index, and no tag or valid bit changes.
- R7: Any tag can live in any sector. All sectors are compared at once, and a hit in any sector reports that sector's index.
- R8: `rsp_fwd_write` is high in the response to every write, whatever the lookup result. It is low for reads.
- R9: A write never allocates. It changes no tag and no sector-valid bit, and a later read of the same address still misses.
- R10: When a sector is taken over by a new tag, later lookups of the old tag are sector misses. Blocks that were valid under the old tag read as block misses under the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 16 | Word address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| victim_sector | input | 2 | Sector to replace on a read sector miss, from the replacement unit |
| fill_valid | input | 1 | Block install this cycle |
| fill_sector | input | 2 | Sector receiving the block |
| fill_block | input | 4 | Block slot being installed |
| rsp_valid | output | 1 | Response present (registered) |
| rsp_hit | output | 1 | Tag matched and block valid |
| rsp_blk_miss | output | 1 | Tag matched, block not valid |
| rsp_sec_miss | output | 1 | No tag matched |
| rsp_sector | output | 2 | Matching sector, or victim on a sector miss |
| rsp_fwd_write | output | 1 | Write forwarded to backing store |

## Verification
The bound checker watches several rules on every cycle:

- the one-cycle request-to-response timing and the single-result encoding;
- write forwarding;
- writes leaving tags and sector-valid bits unchanged;
- a read sector miss leaving the reported sector valid and holding the request's tag;
- every hit pointing at a block whose valid bit is set;
- reset emptying the directory.

The rest can only be shown by the bench's ordered scenarios. These cover fills followed by hits, block misses under a resident tag, and word bits being ignored. They also cover four tags living side by side, an old tag being evicted along with its blocks, and misses after a mid-run reset.

// File: rtl/sdir_pkg.sv
package sdir_pkg;
  typedef enum logic [1:0] {
    LOOK_HIT     = 2'd0,
    LOOK_BLKMISS = 2'd1,
    LOOK_SECMISS = 2'd2
  } look_kind_e;
endpackage

// File: rtl/sdir_match.sv
module sdir_match #(
  parameter int NUM_SEC = 4,
  parameter int TAG_W   = 10,
  localparam int SEC_W  = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
  input  logic [NUM_SEC-1:0][TAG_W-1:0] tags,
  input  logic [NUM_SEC-1:0]            sec_ok,
  input  logic [TAG_W-1:0]              probe,
  output logic                          any,
  output logic [SEC_W-1:0]              idx
);
  logic [NUM_SEC-1:0] eq;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_cmp
    assign eq[s] = sec_ok[s] && (tags[s] == probe);
  end

  always_comb begin
    any = |eq;
    idx = '0;
    for (int s = NUM_SEC - 1; s >= 0; s--) begin
      if (eq[s]) idx = SEC_W'(s);
    end
  end
endmodule

// File: rtl/sdir_store.sv
module sdir_store #(
  parameter int NUM_SEC = 4,
  parameter int TAG_W   = 10,
  parameter int BLKS    = 16,
  localparam int SEC_W  = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
  localparam int BLK_W  = (BLKS > 1) ? $clog2(BLKS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_en,
  input  logic [SEC_W-1:0]              alloc_idx,
  input  logic [TAG_W-1:0]              alloc_tag,
  input  logic                          fill_en,
  input  logic [SEC_W-1:0]              fill_idx,
  input  logic [BLK_W-1:0]              fill_blk,
  output logic [NUM_SEC-1:0][TAG_W-1:0] tags_q,
  output logic [NUM_SEC-1:0]            sec_ok_q,
  output logic [NUM_SEC-1:0][BLKS-1:0]  blk_ok_q
);
  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    logic take, put;
    assign take = alloc_en && (alloc_idx == SEC_W'(s));
    assign put  = fill_en  && (fill_idx  == SEC_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        tags_q[s]   <= '0;
        sec_ok_q[s] <= 1'b0;
        blk_ok_q[s] <= '0;
      end else if (take) begin
        // reallocation wins over a fill aimed at the same sector
        tags_q[s]   <= alloc_tag;
        sec_ok_q[s] <= 1'b1;
        blk_ok_q[s] <= '0;
      end else if (put) begin
        blk_ok_q[s][fill_blk] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sector_dir.sv
module sector_dir
  import sdir_pkg::*;
#(
  parameter int NUM_SEC = 4,
  parameter int ADDR_W  = 16,
  parameter int WORDS   = 4,
  parameter int BLKS    = 16,
  localparam int SEC_W  = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BLK_W  = (BLKS > 1) ? $clog2(BLKS) : 1,
  localparam int TAG_W  = ADDR_W - WORD_W - BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [SEC_W-1:0]  victim_sector,
  input  logic              fill_valid,
  input  logic [SEC_W-1:0]  fill_sector,
  input  logic [BLK_W-1:0]  fill_block,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_blk_miss,
  output logic              rsp_sec_miss,
  output logic [SEC_W-1:0]  rsp_sector,
  output logic              rsp_fwd_write
);
  logic [TAG_W-1:0]              tag_in;
  logic [BLK_W-1:0]              blk_in;
  logic [NUM_SEC-1:0][TAG_W-1:0] tags_q;
  logic [NUM_SEC-1:0]            sec_ok_q;
  logic [NUM_SEC-1:0][BLKS-1:0]  blk_ok_q;
  logic                          hit_any;
  logic [SEC_W-1:0]              hit_idx;
  logic                          alloc_en;
  look_kind_e                    kind;
  logic [SEC_W-1:0]              sec_d;

  assign tag_in = req_addr[ADDR_W-1 -: TAG_W];
  assign blk_in = req_addr[WORD_W +: BLK_W];

  sdir_match #(.NUM_SEC(NUM_SEC), .TAG_W(TAG_W)) u_match (
    .tags   (tags_q),
    .sec_ok (sec_ok_q),
    .probe  (tag_in),
    .any    (hit_any),
    .idx    (hit_idx)
  );

  always_comb begin
    if (!hit_any)                   kind = LOOK_SECMISS;
    else if (blk_ok_q[hit_idx][blk_in]) kind = LOOK_HIT;
    else                            kind = LOOK_BLKMISS;
    sec_d    = hit_any ? hit_idx : victim_sector;
    alloc_en = req_valid && !req_write && !hit_any;
  end

  sdir_store #(.NUM_SEC(NUM_SEC), .TAG_W(TAG_W), .BLKS(BLKS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (alloc_en),
    .alloc_idx (victim_sector),
    .alloc_tag (tag_in),
    .fill_en   (fill_valid),
    .fill_idx  (fill_sector),
    .fill_blk  (fill_block),
    .tags_q    (tags_q),
    .sec_ok_q  (sec_ok_q),
    .blk_ok_q  (blk_ok_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_blk_miss  <= 1'b0;
      rsp_sec_miss  <= 1'b0;
      rsp_sector    <= '0;
      rsp_fwd_write <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_hit       <= req_valid && (kind == LOOK_HIT);
      rsp_blk_miss  <= req_valid && (kind == LOOK_BLKMISS);
      rsp_sec_miss  <= req_valid && (kind == LOOK_SECMISS);
      rsp_sector    <= req_valid ? sec_d : '0;
      rsp_fwd_write <= req_valid && req_write;
    end
  end
endmodule

// File: rtl/sector_dir_chk.sv
module sector_dir_chk #(
  parameter int NUM_SEC = 4,
  parameter int ADDR_W  = 16,
  parameter int TAG_W   = 10,
  parameter int BLKS    = 16,
  parameter int WORD_W  = 2,
  parameter int BLK_W   = 4,
  parameter int SEC_W   = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          req_valid,
  input logic [ADDR_W-1:0]             req_addr,
  input logic                          req_write,
  input logic                          rsp_valid,
  input logic                          rsp_hit,
  input logic                          rsp_blk_miss,
  input logic                          rsp_sec_miss,
  input logic [SEC_W-1:0]              rsp_sector,
  input logic                          rsp_fwd_write,
  input logic [NUM_SEC-1:0][TAG_W-1:0] tags_q,
  input logic [NUM_SEC-1:0]            sec_ok_q,
  input logic [NUM_SEC-1:0][BLKS-1:0]  blk_ok_q
);
  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> (sec_ok_q == '0) && (blk_ok_q == '0) && !rsp_valid);

  assert_rsp_timing_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_one_result_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_blk_miss, rsp_sec_miss}) == 1));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_blk_miss || rsp_sec_miss || rsp_fwd_write));

  assert_fwd_write_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_fwd_write == $past(req_write)));

  assert_write_no_alloc_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> ($stable(sec_ok_q) && $stable(tags_q)));

  assert_miss_installs_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_sec_miss && !rsp_fwd_write) |->
      (sec_ok_q[rsp_sector] &&
       (tags_q[rsp_sector] == $past(req_addr[ADDR_W-1 -: TAG_W]))));

  assert_hit_block_valid_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> blk_ok_q[rsp_sector][$past(req_addr[WORD_W +: BLK_W])]);
endmodule

bind sector_dir sector_dir_chk #(
  .NUM_SEC(NUM_SEC), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .BLKS(BLKS),
  .WORD_W(WORD_W), .BLK_W(BLK_W), .SEC_W(SEC_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_blk_miss(rsp_blk_miss), .rsp_sec_miss(rsp_sec_miss),
  .rsp_sector(rsp_sector), .rsp_fwd_write(rsp_fwd_write),
  .tags_q(tags_q), .sec_ok_q(sec_ok_q), .blk_ok_q(blk_ok_q)
);

// File: tb/sim_sector_dir.sv
module sim_sector_dir;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  victim_sector = '0;
  logic        fill_valid = 1'b0;
  logic [1:0]  fill_sector = '0;
  logic [3:0]  fill_block = '0;
  logic        rsp_valid, rsp_hit, rsp_blk_miss, rsp_sec_miss, rsp_fwd_write;
  logic [1:0]  rsp_sector;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sector_dir u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .victim_sector(victim_sector),
    .fill_valid(fill_valid), .fill_sector(fill_sector), .fill_block(fill_block),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_blk_miss(rsp_blk_miss),
    .rsp_sec_miss(rsp_sec_miss), .rsp_sector(rsp_sector),
    .rsp_fwd_write(rsp_fwd_write)
  );

  // op: 0 read, 1 write, 2 fill (sector = sec, block = addr[5:2])
  // kind: 0 hit, 1 block miss, 2 sector miss
  localparam int NV = 22;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 16'h004C, 2'd0, 2'd2, 2'd0}, // R1 R4 empty after reset
    {2'd0, 16'h004C, 2'd0, 2'd1, 2'd0}, // R4 blocks cleared
    {2'd2, 16'h004C, 2'd0, 2'd0, 2'd0}, // fill s0 b3
    {2'd0, 16'h004F, 2'd1, 2'd0, 2'd0}, // R5 R2 word bits ignored
    {2'd0, 16'h0050, 2'd1, 2'd1, 2'd0}, // R2 R6 other slot
    {2'd0, 16'h008C, 2'd1, 2'd2, 2'd1}, // R7 second tag
    {2'd2, 16'h008C, 2'd1, 2'd0, 2'd0}, // fill s1 b3
    {2'd0, 16'h008C, 2'd3, 2'd0, 2'd1}, // R7
    {2'd0, 16'h004D, 2'd3, 2'd0, 2'd0}, // R7 first tag still there
    {2'd1, 16'h00C0, 2'd2, 2'd2, 2'd2}, // R8 R9 write miss
    {2'd0, 16'h00C0, 2'd2, 2'd2, 2'd2}, // R9 write did not allocate
    {2'd2, 16'h00C0, 2'd2, 2'd0, 2'd0}, // fill s2 b0
    {2'd0, 16'h00C2, 2'd0, 2'd0, 2'd2}, // R5
    {2'd1, 16'h004C, 2'd3, 2'd0, 2'd0}, // R8 write hit
    {2'd0, 16'h0100, 2'd3, 2'd2, 2'd3}, // R7 fourth sector
    {2'd2, 16'h0104, 2'd3, 2'd0, 2'd0}, // fill s3 b1
    {2'd0, 16'h0107, 2'd0, 2'd0, 2'd3}, // R7
    {2'd0, 16'hFFFC, 2'd0, 2'd2, 2'd0}, // R10 take over s0
    {2'd0, 16'h004C, 2'd3, 2'd2, 2'd3}, // R10 old tag gone
    {2'd0, 16'hFFCC, 2'd1, 2'd1, 2'd0}, // R10 old block not valid
    {2'd0, 16'h008C, 2'd0, 2'd0, 2'd1}, // R7 untouched sector
    {2'd1, 16'hFFCC, 2'd2, 2'd1, 2'd0}  // R8 write block miss
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [15:0] a, input logic w, input logic [1:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; victim_sector = v;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_fill(input logic [1:0] s, input logic [3:0] b);
    @(negedge clk);
    fill_valid = 1'b1; fill_sector = s; fill_block = b;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  function automatic int flags(input logic [1:0] k);
    return (k == 2'd0) ? 4 : (k == 2'd1) ? 2 : 1;
  endfunction

  task automatic check_rsp(input string req, input logic [1:0] k,
                           input logic [1:0] s, input logic w);
    check(req, {29'd0, rsp_hit, rsp_blk_miss, rsp_sec_miss}, flags(k));
    check("R7 sector", int'(rsp_sector), int'(s));
    check("R8 fwd", int'(rsp_fwd_write), int'(w));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state of outputs
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 flags", {29'd0, rsp_hit, rsp_blk_miss, rsp_sec_miss}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op, sec, kd, es;
      logic [15:0] ad;
      {op, ad, sec, kd, es} = VEC[i];
      if (op == 2'd2) begin
        do_fill(sec, ad[5:2]);
      end else begin
        do_req(ad, op[0], sec);
        check("R3 valid", int'(rsp_valid), 1);
        case (kd)
          2'd0:    check_rsp("R5 hit", kd, es, op[0]);
          2'd1:    check_rsp("R6 block miss", kd, es, op[0]);
          default: check_rsp("R4 sector miss", kd, es, op[0]);
        endcase
      end
    end

    // R3: idle cycle after a response leaves outputs quiet
    @(negedge clk);
    check("R3 idle valid", int'(rsp_valid), 0);
    check("R3 idle flags", {29'd0, rsp_hit, rsp_blk_miss, rsp_sec_miss}, 0);

    // R9: write on a block miss does not fill the block
    do_req(16'h0050 + 16'h0100, 1'b1, 2'd0); // tag 5 absent: sector miss
    check_rsp("R9 write miss", 2'd2, 2'd0, 1'b1);
    do_req(16'hFFCC, 1'b0, 2'd2);
    check_rsp("R9 block stays invalid", 2'd1, 2'd0, 1'b0);
    do_req(16'h0150, 1'b0, 2'd2); // tag 5 still absent, now installed in s2
    check_rsp("R9 no alloc by write", 2'd2, 2'd2, 1'b0);

    // R2: upper tag bit distinguishes sectors (tag 0x201 vs tag 1)
    do_req(16'h804C, 1'b0, 2'd1);
    check_rsp("R2 tag width", 2'd2, 2'd1, 1'b0);

    // R1: mid-run reset empties the directory
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 outputs after reset", int'(rsp_valid), 0);
    do_req(16'h008C, 1'b0, 2'd3);
    check_rsp("R1 miss after reset", 2'd2, 2'd3, 1'b0);
    do_req(16'h0107, 1'b0, 2'd0);
    check_rsp("R1 miss after reset", 2'd2, 2'd0, 1'b0);
    do_req(16'h008C, 1'b0, 2'd0);
    check_rsp("R10 blocks empty after install", 2'd1, 2'd3, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule